// File: doc/BRIEF.md
# DDR4 Command/Address Decoder

This block watches a DDR4-style command/address bus and turns each rising clock edge into one decoded command. On every edge it samples chip select, clock enable, the activate strobe, the three multiplexed command pins, the bank group and bank inputs and the low address bits. It then presents, one cycle later, a single-cycle command strobe together with the fields that belong to that command. Those fields are the row or column, the bank group and bank, the auto-precharge, precharge-all and chopped-burst flags, and the mode-register selector with its op-code.

The activate strobe changes how the rest of the bus is read. When it is low, the three command pins are not a command code but the top three row bits, so the full row is built from them and the address bits. When it is high, those pins pick a read, write, precharge, refresh, mode-register write or no-operation. Codes outside that set are flagged as illegal. An even-parity check, selected by a parameter, covers the whole command word. A parity mismatch raises a one-cycle alert and drops the command. A controller model, a protocol monitor or a memory-side front end uses the block to get a clean, typed command stream.

Top module: `cad_decoder`

## Requirements
- R1: A cycle sampled with `cs_n_i` high issues nothing: `cmd_valid_o`, `illegal_o` and `alert_o` stay low and `cmd_o` reads 0, whatever the other inputs, parity included.
- R2: A cycle sampled with `cke_i` low issues nothing, in the same way as R1.
- R3: With `cs_n_i` low, `cke_i` high and `act_n_i` low, the command is an activate (`cmd_o` = 1). `row_o` = {ras_n, cas_n, we_n, addr[13:0]} with ras_n in bit 16. The bank group and bank are passed on unchanged.
- R4: With `act_n_i` high, {ras_n, cas_n, we_n} selects the command: 000 mode-register write (`cmd_o` = 5), 001 refresh (6), 010 precharge (4), 100 write (3), 101 read (2), 111 no-operation (7). Refresh and no-operation carry no fields.
- R5: The patterns 011 and 110 with `act_n_i` high give a one-cycle `illegal_o` pulse and no `cmd_valid_o`.
- R6: On a read or write, `col_o` = addr[9:0], `auto_pre_o` = addr[10], and `burst_chop_o` = NOT addr[12] (addr[12] low means a chopped burst of 4). The bank group and bank are passed on.
- R7: On a precharge, `pre_all_o` = addr[10], and the bank group and bank are passed on.
- R8: On a mode-register write, `mr_sel_o` = {bg[0], ba[1], ba[0]} and `opcode_o` = addr[13:0].
- R9: Even parity holds when the XOR of act_n, ras_n, cas_n, we_n, bg, ba, addr and `par_i` is 0. On a command cycle (cs_n low, cke high), a mismatch gives a one-cycle `alert_o` and suppresses both the command and `illegal_o`.
- R10: Every field that a cycle's command does not use reads zero, and when no command is valid all fields read zero.
- R11: The outputs change on the clock edge after the one that sampled the inputs, and `cmd_valid_o` is a single-cycle strobe. An asynchronous low on `rst_n` clears every output at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| cke_i | input | 1 | Clock enable |
| act_n_i | input | 1 | Activate strobe, active low |
| ras_n_i | input | 1 | Command pin / row bit 16 |
| cas_n_i | input | 1 | Command pin / row bit 15 |
| we_n_i | input | 1 | Command pin / row bit 14 |
| bg_i | input | 2 | Bank group |
| ba_i | input | 2 | Bank within group |
| addr_i | input | 14 | Address bits 13..0 |
| par_i | input | 1 | Even-parity bit over the command word |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_o | output | 3 | Command code (R4 encoding) |
| row_o | output | 17 | Row address on activate |
| col_o | output | 10 | Column on read/write |
| bg_o | output | 2 | Bank group of the command |
| ba_o | output | 2 | Bank of the command |
| auto_pre_o | output | 1 | Auto-precharge requested |
| pre_all_o | output | 1 | Precharge applies to all banks |
| burst_chop_o | output | 1 | Chopped burst of 4 |
| mr_sel_o | output | 3 | Mode register selected |
| opcode_o | output | 14 | Mode-register op-code |
| illegal_o | output | 1 | Undefined command code seen |
| alert_o | output | 1 | Parity mismatch seen |

## Verification
The assertions check on every cycle that deselect and clock-enable-low cycles stay silent, and that the strobe, illegal and alert outputs never rise together. They also check that a valid command always came from a word with good parity, and that an activate's row and a read/write's burst flag match the sampled pins. The bench scenarios cover the rest: the full command-code table, the field mapping for each command type, the one-cycle width of the alert and illegal pulses, and the asynchronous reset taking effect in the middle of a cycle.

// File: rtl/cad_pkg.sv
package cad_pkg;
    typedef enum logic [2:0] {
        CMD_DES = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_MRS = 3'd5,
        CMD_REF = 3'd6,
        CMD_NOP = 3'd7
    } cad_cmd_e;
endpackage

// File: rtl/cad_classify.sv
module cad_classify
    import cad_pkg::*;
(
    input  logic     act_n_i,
    input  logic     ras_n_i,
    input  logic     cas_n_i,
    input  logic     we_n_i,
    output cad_cmd_e cmd_o,
    output logic     legal_o
);
    always_comb begin
        legal_o = 1'b1;
        cmd_o   = CMD_DES;
        if (!act_n_i) begin
            cmd_o = CMD_ACT;
        end else begin
            unique case ({ras_n_i, cas_n_i, we_n_i})
                3'b000:  cmd_o = CMD_MRS;
                3'b001:  cmd_o = CMD_REF;
                3'b010:  cmd_o = CMD_PRE;
                3'b100:  cmd_o = CMD_WR;
                3'b101:  cmd_o = CMD_RD;
                3'b111:  cmd_o = CMD_NOP;
                default: legal_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cad_parity.sv
module cad_parity #(
    parameter int DATA_W = 8,
    parameter bit EN     = 1'b1
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              par_i,
    output logic              ok_o
);
    generate
        if (EN) begin : g_check
            // even parity: data plus parity bit XOR to zero
            assign ok_o = ~(^{data_i, par_i});
        end else begin : g_bypass
            logic unused_par;
            assign unused_par = ^{data_i, par_i};
            assign ok_o       = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/cad_fields.sv
module cad_fields
    import cad_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int COL_W  = 10,
    parameter int BG_W   = 2,
    parameter int BA_W   = 2
) (
    input  cad_cmd_e              cmd_i,
    input  logic                  ras_n_i,
    input  logic                  cas_n_i,
    input  logic                  we_n_i,
    input  logic [BG_W-1:0]       bg_i,
    input  logic [BA_W-1:0]       ba_i,
    input  logic [ADDR_W-1:0]     addr_i,
    output logic [ADDR_W+2:0]     row_o,
    output logic [COL_W-1:0]      col_o,
    output logic [BG_W-1:0]       bg_o,
    output logic [BA_W-1:0]       ba_o,
    output logic                  auto_pre_o,
    output logic                  pre_all_o,
    output logic                  burst_chop_o,
    output logic [BA_W:0]         mr_sel_o,
    output logic [ADDR_W-1:0]     opcode_o
);
    localparam int AP_BIT = 10;
    localparam int BC_BIT = 12;

    always_comb begin
        row_o        = '0;
        col_o        = '0;
        bg_o         = '0;
        ba_o         = '0;
        auto_pre_o   = 1'b0;
        pre_all_o    = 1'b0;
        burst_chop_o = 1'b0;
        mr_sel_o     = '0;
        opcode_o     = '0;
        case (cmd_i)
            CMD_ACT: begin
                row_o = {ras_n_i, cas_n_i, we_n_i, addr_i};
                bg_o  = bg_i;
                ba_o  = ba_i;
            end
            CMD_RD, CMD_WR: begin
                col_o        = addr_i[COL_W-1:0];
                auto_pre_o   = addr_i[AP_BIT];
                burst_chop_o = ~addr_i[BC_BIT];
                bg_o         = bg_i;
                ba_o         = ba_i;
            end
            CMD_PRE: begin
                pre_all_o = addr_i[AP_BIT];
                bg_o      = bg_i;
                ba_o      = ba_i;
            end
            CMD_MRS: begin
                mr_sel_o = {bg_i[0], ba_i};
                opcode_o = addr_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cad_decoder.sv
module cad_decoder
    import cad_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int COL_W  = 10,
    parameter int BG_W   = 2,
    parameter int BA_W   = 2,
    parameter bit PAR_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              cke_i,
    input  logic              act_n_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic [BG_W-1:0]   bg_i,
    input  logic [BA_W-1:0]   ba_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              par_i,
    output logic              cmd_valid_o,
    output logic [2:0]        cmd_o,
    output logic [ADDR_W+2:0] row_o,
    output logic [COL_W-1:0]  col_o,
    output logic [BG_W-1:0]   bg_o,
    output logic [BA_W-1:0]   ba_o,
    output logic              auto_pre_o,
    output logic              pre_all_o,
    output logic              burst_chop_o,
    output logic [BA_W:0]     mr_sel_o,
    output logic [ADDR_W-1:0] opcode_o,
    output logic              illegal_o,
    output logic              alert_o
);
    localparam int ROW_W = ADDR_W + 3;
    localparam int MR_W  = BA_W + 1;
    localparam int PAR_W = 4 + BG_W + BA_W + ADDR_W;

    typedef struct packed {
        logic              valid;
        cad_cmd_e          cmd;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [BG_W-1:0]   bg;
        logic [BA_W-1:0]   ba;
        logic              auto_pre;
        logic              pre_all;
        logic              chop;
        logic [MR_W-1:0]   mr_sel;
        logic [ADDR_W-1:0] opcode;
        logic              illegal;
        logic              alert;
    } dec_t;

    dec_t st_d, st_q;

    cad_cmd_e          kind_w;
    logic              legal_w;
    logic              par_ok_w;
    logic [ROW_W-1:0]  f_row;
    logic [COL_W-1:0]  f_col;
    logic [BG_W-1:0]   f_bg;
    logic [BA_W-1:0]   f_ba;
    logic              f_ap, f_pall, f_bc;
    logic [MR_W-1:0]   f_mr;
    logic [ADDR_W-1:0] f_op;

    cad_classify u_classify (
        .act_n_i (act_n_i),
        .ras_n_i (ras_n_i),
        .cas_n_i (cas_n_i),
        .we_n_i  (we_n_i),
        .cmd_o   (kind_w),
        .legal_o (legal_w)
    );

    cad_parity #(.DATA_W(PAR_W), .EN(PAR_EN)) u_parity (
        .data_i ({act_n_i, ras_n_i, cas_n_i, we_n_i, bg_i, ba_i, addr_i}),
        .par_i  (par_i),
        .ok_o   (par_ok_w)
    );

    cad_fields #(.ADDR_W(ADDR_W), .COL_W(COL_W), .BG_W(BG_W), .BA_W(BA_W)) u_fields (
        .cmd_i        (kind_w),
        .ras_n_i      (ras_n_i),
        .cas_n_i      (cas_n_i),
        .we_n_i       (we_n_i),
        .bg_i         (bg_i),
        .ba_i         (ba_i),
        .addr_i       (addr_i),
        .row_o        (f_row),
        .col_o        (f_col),
        .bg_o         (f_bg),
        .ba_o         (f_ba),
        .auto_pre_o   (f_ap),
        .pre_all_o    (f_pall),
        .burst_chop_o (f_bc),
        .mr_sel_o     (f_mr),
        .opcode_o     (f_op)
    );

    always_comb begin
        logic cmd_cycle;
        cmd_cycle = !cs_n_i && cke_i;
        st_d      = '0;
        if (cmd_cycle && !par_ok_w) begin
            st_d.alert = 1'b1;
        end else if (cmd_cycle && !legal_w) begin
            st_d.illegal = 1'b1;
        end else if (cmd_cycle) begin
            st_d.valid    = 1'b1;
            st_d.cmd      = kind_w;
            st_d.row      = f_row;
            st_d.col      = f_col;
            st_d.bg       = f_bg;
            st_d.ba       = f_ba;
            st_d.auto_pre = f_ap;
            st_d.pre_all  = f_pall;
            st_d.chop     = f_bc;
            st_d.mr_sel   = f_mr;
            st_d.opcode   = f_op;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_valid_o  = st_q.valid;
    assign cmd_o        = st_q.cmd;
    assign row_o        = st_q.row;
    assign col_o        = st_q.col;
    assign bg_o         = st_q.bg;
    assign ba_o         = st_q.ba;
    assign auto_pre_o   = st_q.auto_pre;
    assign pre_all_o    = st_q.pre_all;
    assign burst_chop_o = st_q.chop;
    assign mr_sel_o     = st_q.mr_sel;
    assign opcode_o     = st_q.opcode;
    assign illegal_o    = st_q.illegal;
    assign alert_o      = st_q.alert;
endmodule

// File: rtl/cad_decoder_chk.sv
module cad_decoder_chk
    import cad_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int COL_W  = 10,
    parameter int BG_W   = 2,
    parameter int BA_W   = 2,
    parameter bit PAR_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_i,
    input logic              cke_i,
    input logic              act_n_i,
    input logic              ras_n_i,
    input logic              cas_n_i,
    input logic              we_n_i,
    input logic [BG_W-1:0]   bg_i,
    input logic [BA_W-1:0]   ba_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              par_i,
    input logic              cmd_valid_o,
    input logic [2:0]        cmd_o,
    input logic [ADDR_W+2:0] row_o,
    input logic [COL_W-1:0]  col_o,
    input logic              burst_chop_o,
    input logic [ADDR_W-1:0] opcode_o,
    input logic              illegal_o,
    input logic              alert_o
);
    AST_DESELECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n_i) |-> (!cmd_valid_o && !illegal_o && !alert_o)); // R1

    AST_CKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cke_i) |-> (!cmd_valid_o && !illegal_o && !alert_o)); // R2

    AST_ACT_ROW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_o == CMD_ACT) |->
        row_o == {$past(ras_n_i), $past(cas_n_i), $past(we_n_i), $past(addr_i)}); // R3

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid_o, illegal_o, alert_o})); // R5

    AST_CHOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && (cmd_o == CMD_RD || cmd_o == CMD_WR)) |->
        burst_chop_o == !$past(addr_i[12])); // R6

    AST_VALID_HAS_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (!PAR_EN || (^{$past(act_n_i), $past(ras_n_i), $past(cas_n_i),
        $past(we_n_i), $past(bg_i), $past(ba_i), $past(addr_i), $past(par_i)}) == 1'b0)); // R9

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_o |-> (cmd_o == 3'd0 && row_o == '0 && col_o == '0 && opcode_o == '0)); // R10
endmodule

bind cad_decoder cad_decoder_chk #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .BG_W(BG_W), .BA_W(BA_W), .PAR_EN(PAR_EN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n_i       (cs_n_i),
    .cke_i        (cke_i),
    .act_n_i      (act_n_i),
    .ras_n_i      (ras_n_i),
    .cas_n_i      (cas_n_i),
    .we_n_i       (we_n_i),
    .bg_i         (bg_i),
    .ba_i         (ba_i),
    .addr_i       (addr_i),
    .par_i        (par_i),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_o        (cmd_o),
    .row_o        (row_o),
    .col_o        (col_o),
    .burst_chop_o (burst_chop_o),
    .opcode_o     (opcode_o),
    .illegal_o    (illegal_o),
    .alert_o      (alert_o)
);

// File: tb/cad_decoder_test.sv
`timescale 1ns/1ps
module cad_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, cke = 1'b1, act_n = 1'b1;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  bg = '0, ba = '0;
    logic [13:0] addr = '0;
    logic        par = 1'b1;

    logic        cmd_valid, auto_pre, pre_all, chop, illegal, alert;
    logic [2:0]  cmd, mr_sel;
    logic [16:0] row;
    logic [9:0]  col;
    logic [1:0]  bg_q, ba_q;
    logic [13:0] opcode;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cad_decoder uut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .cke_i(cke), .act_n_i(act_n),
        .ras_n_i(ras_n), .cas_n_i(cas_n), .we_n_i(we_n), .bg_i(bg), .ba_i(ba),
        .addr_i(addr), .par_i(par), .cmd_valid_o(cmd_valid), .cmd_o(cmd),
        .row_o(row), .col_o(col), .bg_o(bg_q), .ba_o(ba_q), .auto_pre_o(auto_pre),
        .pre_all_o(pre_all), .burst_chop_o(chop), .mr_sel_o(mr_sel),
        .opcode_o(opcode), .illegal_o(illegal), .alert_o(alert)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic chk_quiet(input string req);
        chk(req, "valid", cmd_valid, 0);
        chk(req, "illegal", illegal, 0);
        chk(req, "alert", alert, 0);
        chk(req, "cmd", cmd, 0);
        chk(req, "fields", {row, col, opcode, mr_sel, bg_q, ba_q}, 0);
    endtask

    // drive one cycle at a falling edge, then deselect at the next falling edge
    task automatic issue(input logic c, input logic k, input logic a, input logic r,
                         input logic s, input logic w, input logic [1:0] g,
                         input logic [1:0] b, input logic [13:0] ad, input logic flip);
        @(negedge clk);
        cs_n = c; cke = k; act_n = a; ras_n = r; cas_n = s; we_n = w;
        bg = g; ba = b; addr = ad;
        par = (^{a, r, s, w, g, b, ad}) ^ flip;
        @(negedge clk);
        cs_n = 1'b1; cke = 1'b1;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk_quiet("R11 reset");
        rst_n = 1'b1;
    endtask

    task automatic t_deselect;
        issue(1, 1, 0, 1, 0, 1, 2'd3, 2'd1, 14'h3FFF, 0);
        chk_quiet("R1 deselect act");
        issue(1, 1, 1, 1, 0, 1, 2'd0, 2'd0, 14'h0123, 1);
        chk_quiet("R1 deselect badpar");
    endtask

    task automatic t_cke_low;
        issue(0, 0, 1, 1, 0, 1, 2'd1, 2'd1, 14'h0555, 0);
        chk_quiet("R2 cke low read");
        issue(0, 0, 1, 0, 1, 1, 2'd1, 2'd1, 14'h0555, 0);
        chk_quiet("R2 cke low illegal");
    endtask

    task automatic t_activate;
        issue(0, 1, 0, 1, 0, 1, 2'd2, 2'd3, 14'h2A5C, 0);
        chk("R3", "valid", cmd_valid, 1);
        chk("R3", "cmd", cmd, 1);
        chk("R3", "row", row, {3'b101, 14'h2A5C});
        chk("R3", "bg", bg_q, 2);
        chk("R3", "ba", ba_q, 3);
        chk("R10 act", "col", col, 0);
        @(negedge clk);
        chk("R11 strobe", "valid", cmd_valid, 0);
        issue(0, 1, 0, 0, 0, 0, 2'd1, 2'd0, 14'h1001, 0);
        chk("R3 low pins", "cmd", cmd, 1);
        chk("R3 low pins", "row", row, {3'b000, 14'h1001});
    endtask

    task automatic t_rdwr;
        issue(0, 1, 1, 1, 0, 1, 2'd1, 2'd2, 14'h05A7, 0);
        chk("R4 read", "cmd", cmd, 2);
        chk("R6 read", "col", col, 10'h1A7);
        chk("R6 read", "ap", auto_pre, 1);
        chk("R6 read", "chop", chop, 1);
        chk("R6 read", "bgba", {bg_q, ba_q}, 4'b0110);
        chk("R10 read", "row", row, 0);
        issue(0, 1, 1, 1, 0, 0, 2'd3, 2'd0, 14'h1123, 0);
        chk("R4 write", "cmd", cmd, 3);
        chk("R6 write", "col", col, 10'h123);
        chk("R6 write", "ap", auto_pre, 0);
        chk("R6 write", "chop", chop, 0);
        chk("R6 write", "bgba", {bg_q, ba_q}, 4'b1100);
    endtask

    task automatic t_pre;
        issue(0, 1, 1, 0, 1, 0, 2'd0, 2'd0, 14'h0400, 0);
        chk("R4 pre", "cmd", cmd, 4);
        chk("R7 all", "pall", pre_all, 1);
        issue(0, 1, 1, 0, 1, 0, 2'd1, 2'd2, 14'h0000, 0);
        chk("R7 one", "pall", pre_all, 0);
        chk("R7 one", "bgba", {bg_q, ba_q}, 4'b0110);
        chk("R10 pre", "ap", auto_pre, 0);
    endtask

    task automatic t_mrs;
        issue(0, 1, 1, 0, 0, 0, 2'd3, 2'd2, 14'h1ABC, 0);
        chk("R4 mrs", "cmd", cmd, 5);
        chk("R8", "mr_sel", mr_sel, 3'd6);
        chk("R8", "opcode", opcode, 14'h1ABC);
        chk("R10 mrs", "col", col, 0);
        chk("R10 mrs", "bg", bg_q, 0);
    endtask

    task automatic t_ref_nop;
        issue(0, 1, 1, 0, 0, 1, 2'd3, 2'd3, 14'h3FFF, 0);
        chk("R4 ref", "valid", cmd_valid, 1);
        chk("R4 ref", "cmd", cmd, 6);
        chk("R10 ref", "fields", {row, col, opcode, mr_sel, bg_q, ba_q, auto_pre, pre_all, chop}, 0);
        issue(0, 1, 1, 1, 1, 1, 2'd2, 2'd1, 14'h2222, 0);
        chk("R4 nop", "cmd", cmd, 7);
        chk("R10 nop", "fields", {row, col, opcode, mr_sel, bg_q, ba_q}, 0);
    endtask

    task automatic t_illegal;
        issue(0, 1, 1, 0, 1, 1, 2'd0, 2'd0, 14'h0000, 0);
        chk("R5 011", "illegal", illegal, 1);
        chk("R5 011", "valid", cmd_valid, 0);
        @(negedge clk);
        chk("R5 pulse", "illegal", illegal, 0);
        issue(0, 1, 1, 1, 1, 0, 2'd1, 2'd1, 14'h0101, 0);
        chk("R5 110", "illegal", illegal, 1);
        chk("R5 110", "valid", cmd_valid, 0);
    endtask

    task automatic t_parity;
        issue(0, 1, 1, 1, 0, 1, 2'd1, 2'd1, 14'h0042, 1);
        chk("R9 bad", "alert", alert, 1);
        chk("R9 bad", "valid", cmd_valid, 0);
        @(negedge clk);
        chk("R9 pulse", "alert", alert, 0);
        issue(0, 1, 1, 0, 1, 1, 2'd0, 2'd0, 14'h0000, 1);
        chk("R9 over illegal", "alert", alert, 1);
        chk("R9 over illegal", "illegal", illegal, 0);
        issue(0, 1, 1, 1, 0, 1, 2'd1, 2'd1, 14'h0042, 0);
        chk("R9 good", "valid", cmd_valid, 1);
        chk("R9 good", "alert", alert, 0);
    endtask

    task automatic t_async;
        issue(0, 1, 1, 1, 0, 1, 2'd2, 2'd2, 14'h0333, 0);
        chk("R11 pre-reset", "valid", cmd_valid, 1);
        #1 rst_n = 1'b0;
        #0.5;
        chk_quiet("R11 async");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_deselect();
        t_cke_low();
        t_activate();
        t_rdwr();
        t_pre();
        t_mrs();
        t_ref_nop();
        t_illegal();
        t_parity();
        t_async();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule